// File: doc/BRIEF.md
# Timer Count Source Selector

This block decides, cycle by cycle, whether a timer counter should advance. It issues a single-cycle, registered count-enable pulse, and everything runs in one system clock domain. A free-running prescaler supplies periodic enables at ratios of 1, 2, 4, 8 and 32. Besides these, the block can use two other sources. One is an external input, which is synchronized and edge-detected before use. The other is a tick from a fast on-chip oscillator.

A 3-bit source code chooses the origin of the pulses. The external source is only honoured under two conditions: its enable bit is set, and the lockout flag (raised by the timer's PWM mode) is clear. A 2-bit field picks which transitions of the external input are counted. The oscillator tick is only honoured while the oscillator is reported as running.

The block also checks the external input for glitches. Any high or low phase shorter than three system clocks sets a sticky error flag, which only a reset clears.

Top module: `tmr_src_sel`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `cnt_en` and `pw_err` are 0.
- R2: With `src_sel` = 3'b000, `cnt_en` is high in every cycle after the first one following the selection.
- R3: With `src_sel` = 3'b001, 3'b010, 3'b011 or 3'b100, `cnt_en` pulses for one cycle, evenly spaced every 2, 4, 8 or 32 cycles respectively. Any 64-cycle window therefore holds 32, 16, 8 or 2 pulses.
- R4: With `src_sel` = 3'b101, `ext_en` = 1 and `pwm_lock` = 0, each synchronized transition of `ext_in` chosen by `edge_sel` gives exactly one pulse. The `edge_sel` encoding is 2'b00 rising, 2'b01 falling, 2'b10 both, and 2'b11 rising.
- R5: With `src_sel` = 3'b101 and `ext_en` = 0, `cnt_en` stays 0.
- R6: With `src_sel` = 3'b101 and `pwm_lock` = 1, `cnt_en` stays 0 whatever the value of `ext_en`.
- R7: With `src_sel` = 3'b110, each cycle in which `osc_tick` is high and `osc_on` is 1 gives one pulse. While `osc_on` is 0, no pulses occur.
- R8: With `src_sel` = 3'b111 (reserved), `cnt_en` stays 0.
- R9: After the first synchronized transition of `ext_in` since reset, a high or low phase shorter than 3 system clocks sets `pw_err`. Phases of 3 or more clocks do not set it. The check runs whatever the value of `src_sel`.
- R10: Once set, `pw_err` stays 1 until `rst`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 3 | Count source code |
| edge_sel | input | 2 | External transition select |
| ext_en | input | 1 | Permits the external source |
| pwm_lock | input | 1 | Blocks the external source |
| osc_on | input | 1 | Fast oscillator is running |
| osc_tick | input | 1 | Fast oscillator tick, one cycle wide |
| ext_in | input | 1 | Asynchronous external count input |
| cnt_en | output | 1 | Registered count-enable pulse |
| pw_err | output | 1 | Sticky short-phase error |

## Verification
The hardest case to reach is the width boundary of R9. A phase of exactly three clocks must pass, while a phase of two clocks, either high or low, must trip the flag. The check is also armed only by the first transition seen after reset. To reach these cases, the stimulus first resets the block, then drives `ext_in` one clock after each edge with exact hold counts (3, 2, 4 clocks). It reads `pw_err` once the two-flop synchronizer has settled, and a second reset separates the high-phase case from the low-phase case. Counts of pulses over windows aligned to multiples of 32 clocks cover the prescaled codes whatever the prescaler phase.

// File: rtl/tss_pkg.sv
package tss_pkg;

  typedef enum logic [2:0] {
    SRC_F1   = 3'b000,
    SRC_D2   = 3'b001,
    SRC_D4   = 3'b010,
    SRC_D8   = 3'b011,
    SRC_D32  = 3'b100,
    SRC_EXT  = 3'b101,
    SRC_OSC  = 3'b110,
    SRC_RSVD = 3'b111
  } src_e;

  typedef enum logic [1:0] {
    EDG_RISE     = 2'b00,
    EDG_FALL     = 2'b01,
    EDG_BOTH     = 2'b10,
    EDG_RISE_ALT = 2'b11
  } edge_e;

  localparam int NUM_TAPS = 5;

  // log2 of the division ratio for each prescaler tap
  function automatic int tap_log2(input int idx);
    case (idx)
      0:       return 0;
      1:       return 1;
      2:       return 2;
      3:       return 3;
      default: return 5;
    endcase
  endfunction

endpackage

// File: rtl/tss_prescaler.sv
module tss_prescaler #(
  parameter int CNT_W    = 5,
  parameter int NUM_TAPS = tss_pkg::NUM_TAPS
) (
  input  logic                clk,
  input  logic                rst,
  output logic [NUM_TAPS-1:0] tap_en
);

  logic [CNT_W-1:0] div_cnt;

  always_ff @(posedge clk) begin
    if (rst) div_cnt <= '0;
    else     div_cnt <= div_cnt + 1'b1;
  end

  for (genvar gi = 0; gi < NUM_TAPS; gi++) begin : g_tap
    localparam int LG = tss_pkg::tap_log2(gi);
    if (LG == 0) begin : g_undiv
      assign tap_en[gi] = 1'b1;
    end else begin : g_div
      assign tap_en[gi] = (div_cnt[LG-1:0] == '0);
    end
  end

endmodule

// File: rtl/tss_ext_edge.sv
module tss_ext_edge #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_PW      = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_in,
  output logic rise,
  output logic fall,
  output logic pw_err
);

  localparam int RUN_W = $clog2(MIN_PW + 1);
  localparam logic [RUN_W-1:0] MIN_V = RUN_W'(MIN_PW);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   lvl;
  logic                   edge_seen;
  logic                   armed;
  logic [RUN_W-1:0]       run_cnt;
  logic                   err_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q[0] <= 1'b0;
    else     sync_q[0] <= ext_in;
  end

  for (genvar gs = 1; gs < SYNC_STAGES; gs++) begin : g_sync
    always_ff @(posedge clk) begin
      if (rst) sync_q[gs] <= 1'b0;
      else     sync_q[gs] <= sync_q[gs-1];
    end
  end

  assign lvl = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl;
  end

  assign edge_seen = lvl ^ prev_q;
  assign rise      = lvl & ~prev_q;
  assign fall      = ~lvl & prev_q;

  // run_cnt holds the length of the current phase, saturating at MIN_PW
  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= '0;
      armed   <= 1'b0;
      err_q   <= 1'b0;
    end else if (edge_seen) begin
      run_cnt <= RUN_W'(1);
      armed   <= 1'b1;
      if (armed && (run_cnt < MIN_V)) err_q <= 1'b1;
    end else if (run_cnt < MIN_V) begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  assign pw_err = err_q;

endmodule

// File: rtl/tss_src_mux.sv
module tss_src_mux #(
  parameter int NUM_TAPS = tss_pkg::NUM_TAPS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [2:0]          src_sel,
  input  logic [1:0]          edge_sel,
  input  logic                ext_en,
  input  logic                pwm_lock,
  input  logic                osc_on,
  input  logic                osc_tick,
  input  logic [NUM_TAPS-1:0] tap_en,
  input  logic                rise,
  input  logic                fall,
  output logic                cnt_en
);
  import tss_pkg::*;

  logic ext_evt;
  logic sel_evt;

  always_comb begin
    case (edge_e'(edge_sel))
      EDG_FALL: ext_evt = fall;
      EDG_BOTH: ext_evt = rise | fall;
      default:  ext_evt = rise;
    endcase
  end

  always_comb begin
    case (src_e'(src_sel))
      SRC_F1:  sel_evt = tap_en[0];
      SRC_D2:  sel_evt = tap_en[1];
      SRC_D4:  sel_evt = tap_en[2];
      SRC_D8:  sel_evt = tap_en[3];
      SRC_D32: sel_evt = tap_en[NUM_TAPS-1];
      SRC_EXT: sel_evt = ext_evt & ext_en & ~pwm_lock;
      SRC_OSC: sel_evt = osc_tick & osc_on;
      default: sel_evt = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_en <= 1'b0;
    else     cnt_en <= sel_evt;
  end

endmodule

// File: rtl/tmr_src_sel.sv
module tmr_src_sel #(
  parameter int PRE_W       = 5,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_PW      = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] src_sel,
  input  logic [1:0] edge_sel,
  input  logic       ext_en,
  input  logic       pwm_lock,
  input  logic       osc_on,
  input  logic       osc_tick,
  input  logic       ext_in,
  output logic       cnt_en,
  output logic       pw_err
);

  localparam int NTAP = tss_pkg::NUM_TAPS;

  logic [NTAP-1:0] tap_en;
  logic            ext_rise;
  logic            ext_fall;

  tss_prescaler #(.CNT_W(PRE_W), .NUM_TAPS(NTAP)) u_pre (
    .clk    (clk),
    .rst    (rst),
    .tap_en (tap_en)
  );

  tss_ext_edge #(.SYNC_STAGES(SYNC_STAGES), .MIN_PW(MIN_PW)) u_ext (
    .clk    (clk),
    .rst    (rst),
    .ext_in (ext_in),
    .rise   (ext_rise),
    .fall   (ext_fall),
    .pw_err (pw_err)
  );

  tss_src_mux #(.NUM_TAPS(NTAP)) u_mux (
    .clk      (clk),
    .rst      (rst),
    .src_sel  (src_sel),
    .edge_sel (edge_sel),
    .ext_en   (ext_en),
    .pwm_lock (pwm_lock),
    .osc_on   (osc_on),
    .osc_tick (osc_tick),
    .tap_en   (tap_en),
    .rise     (ext_rise),
    .fall     (ext_fall),
    .cnt_en   (cnt_en)
  );

endmodule

// File: rtl/tss_checker.sv
module tss_checker (
  input logic       clk,
  input logic       rst,
  input logic [2:0] src_sel,
  input logic       ext_en,
  input logic       pwm_lock,
  input logic       osc_on,
  input logic       ext_rise,
  input logic       ext_fall,
  input logic       cnt_en,
  input logic       pw_err
);

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!cnt_en && !pw_err));

  a_r2_every_cycle: assert property (@(posedge clk) disable iff (rst)
    (src_sel == 3'b000) |=> cnt_en);

  a_r3_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
    ((src_sel >= 3'b001) && (src_sel <= 3'b100) && cnt_en &&
     ($past(src_sel) == src_sel)) |=> !cnt_en);

  a_r4_only_on_edge: assert property (@(posedge clk) disable iff (rst)
    ((src_sel == 3'b101) && !ext_rise && !ext_fall) |=> !cnt_en);

  a_r5_ext_disabled: assert property (@(posedge clk) disable iff (rst)
    ((src_sel == 3'b101) && !ext_en) |=> !cnt_en);

  a_r6_locked_out: assert property (@(posedge clk) disable iff (rst)
    ((src_sel == 3'b101) && pwm_lock) |=> !cnt_en);

  a_r7_osc_off: assert property (@(posedge clk) disable iff (rst)
    ((src_sel == 3'b110) && !osc_on) |=> !cnt_en);

  a_r8_reserved: assert property (@(posedge clk) disable iff (rst)
    (src_sel == 3'b111) |=> !cnt_en);

  a_r9_err_after_edge: assert property (@(posedge clk) disable iff (rst)
    $rose(pw_err) |-> $past(ext_rise || ext_fall));

  a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
    pw_err |=> pw_err);

endmodule

bind tmr_src_sel tss_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .src_sel  (src_sel),
  .ext_en   (ext_en),
  .pwm_lock (pwm_lock),
  .osc_on   (osc_on),
  .ext_rise (ext_rise),
  .ext_fall (ext_fall),
  .cnt_en   (cnt_en),
  .pw_err   (pw_err)
);

// File: tb/tmr_src_sel_bench.sv
`timescale 1ns/1ps
module tmr_src_sel_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] src_sel = 3'b000;
  logic [1:0] edge_sel = 2'b00;
  logic       ext_en = 1'b0;
  logic       pwm_lock = 1'b0;
  logic       osc_on = 1'b0;
  logic       osc_tick = 1'b0;
  logic       ext_in = 1'b0;
  logic       cnt_en;
  logic       pw_err;

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  bit    win_on = 1'b0;
  int    win_cnt = 0;
  int    exp_q[$];
  string tag_q[$];
  event  win_closed;

  always #2.5 clk = ~clk;

  tmr_src_sel u_tmr_src_sel (
    .clk(clk), .rst(rst), .src_sel(src_sel), .edge_sel(edge_sel),
    .ext_en(ext_en), .pwm_lock(pwm_lock), .osc_on(osc_on),
    .osc_tick(osc_tick), .ext_in(ext_in), .cnt_en(cnt_en), .pw_err(pw_err)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string tag, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // monitor: counts pulses inside the window, compares on close
  always @(negedge clk) if (win_on) win_cnt += int'(cnt_en);

  always begin
    @(win_closed);
    if (exp_q.size() > 0) check(tag_q.pop_front(), win_cnt, exp_q.pop_front());
    win_cnt = 0;
  end

  task automatic open_win(string tag, int expv);
    exp_q.push_back(expv);
    tag_q.push_back(tag);
    win_cnt = 0;
    win_on  = 1'b1;
  endtask

  task automatic close_win();
    win_on = 1'b0;
    ->win_closed;
    tick();
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) tick();
    check("R1 cnt_en in reset", int'(cnt_en), 0);
    check("R1 pw_err in reset", int'(pw_err), 0);
    rst = 1'b0;
    tick();
    check("R1 pw_err after reset", int'(pw_err), 0);
  endtask

  task automatic ext_pulse(int hi, int lo);
    ext_in = 1'b1;
    repeat (hi) tick();
    ext_in = 1'b0;
    repeat (lo) tick();
  endtask

  task automatic div_win(string tag, logic [2:0] code, int expv);
    src_sel = code;
    repeat (3) tick();
    open_win(tag, expv);
    repeat (64) tick();
    close_win();
  endtask

  task automatic ext_win(string tag, logic [1:0] es, bit en, bit lk, int hl, int expv);
    src_sel = 3'b101; edge_sel = es; ext_en = en; pwm_lock = lk;
    repeat (6) tick();
    open_win(tag, expv);
    for (int k = 0; k < 5; k++) ext_pulse(hl, hl);
    repeat (8) tick();
    close_win();
  endtask

  task automatic osc_win(string tag, bit on, int expv);
    src_sel = 3'b110; osc_on = on;
    repeat (3) tick();
    open_win(tag, expv);
    for (int k = 0; k < 10; k++) begin
      osc_tick = 1'b1; tick();
      osc_tick = 1'b0; tick(); tick();
    end
    repeat (3) tick();
    close_win();
  endtask

  initial begin
    do_reset();
    div_win("R2 f1", 3'b000, 64);
    div_win("R3 div2", 3'b001, 32);
    div_win("R3 div4", 3'b010, 16);
    div_win("R3 div8", 3'b011, 8);
    div_win("R3 div32", 3'b100, 2);
    ext_win("R4 rising", 2'b00, 1'b1, 1'b0, 4, 5);
    ext_win("R4 falling", 2'b01, 1'b1, 1'b0, 4, 5);
    ext_win("R4 both", 2'b10, 1'b1, 1'b0, 4, 10);
    ext_win("R4 code11 rising", 2'b11, 1'b1, 1'b0, 4, 5);
    ext_win("R5 ext disabled", 2'b10, 1'b0, 1'b0, 3, 0);
    ext_win("R6 locked", 2'b10, 1'b1, 1'b1, 3, 0);
    check("R9 no error at width 3 or 4", int'(pw_err), 0);
    osc_win("R7 osc on", 1'b1, 10);
    osc_win("R7 osc off", 1'b0, 0);
    src_sel = 3'b111;
    repeat (2) tick();
    open_win("R8 reserved", 0);
    repeat (64) tick();
    close_win();

    // width boundary, high phase
    src_sel = 3'b000;
    do_reset();
    ext_pulse(3, 6);
    repeat (4) tick();
    check("R9 high phase of 3 accepted", int'(pw_err), 0);
    ext_pulse(2, 6);
    repeat (4) tick();
    check("R9 high phase of 2 flagged", int'(pw_err), 1);
    ext_pulse(5, 6);
    repeat (4) tick();
    check("R10 flag stays set", int'(pw_err), 1);
    do_reset();
    check("R10 reset clears flag", int'(pw_err), 0);
    // width boundary, low phase
    ext_pulse(4, 2);
    ext_pulse(4, 6);
    repeat (4) tick();
    check("R9 low phase of 2 flagged", int'(pw_err), 1);

    repeat (4) tick();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule